// File: doc/BRIEF.md
# UART Prioritized Interrupt Status Unit

This block gathers every interrupt condition a UART can raise and turns them into one active interrupt line and an 8-bit status code for the host. On each read, the code reports only the most urgent pending source. A source of lower rank becomes visible only after the higher one has been serviced and the status is read again. The status code is a combinational view of the pending state and of the level inputs, so a host read strobe samples the value shown in that same cycle.

The unit tracks seven sources. Line errors, modem changes, transmit-holding-empty events, Xoff detections and CTS/RTS changes arrive as single-cycle pulses and are held in pending flags. Receive-data-ready and receive-timeout arrive as levels from the FIFO logic. Each source is cleared by its own servicing action. The Xoff flag is sticky: it stays set until an Xon arrives. The two extended sources, Xoff and CTS/RTS change, are active only while the extended-feature enable is high. The top two bits of the code mirror the FIFO mode.

Top module: `uart_irq_status`

## Requirements
- R1: After reset, all pending flags, including the sticky Xoff flag, are clear. The status reads {fifo_on, fifo_on, 6'b000001} and irq is 0.
- R2: Status bits 5:0 carry one code per source: line error 0x06, receive timeout 0x0C, receive data 0x04, transmit holding empty 0x02, modem change 0x00, Xoff 0x10, CTS/RTS change 0x20. The src_en bits map as follows: bit0 line, bit1 receive data, bit2 receive timeout, bit3 transmit holding, bit4 modem, bit5 Xoff, bit6 CTS/RTS.
- R3: When several enabled sources are pending, the status reports the first one in this order: line, receive timeout, receive data, transmit holding, modem, Xoff, CTS/RTS.
- R4: Status bits 7:6 both equal fifo_on in every cycle.
- R5: While ext_en is 0, status bits 5:4 read 0 and the Xoff and CTS/RTS sources are not reported. Pulses on xoff_hit and flow_chg are not recorded.
- R6: An Xoff pulse recorded while ext_en is 1 sets a sticky flag. Status reads do not clear it; only an xon_hit pulse does. If both pulses arrive in the same cycle, the flag is set.
- R7: Status bit 0 is 1 exactly when no enabled source is pending. irq equals the inverse of bit 0.
- R8: The transmit-holding flag is set by thr_evt. It is cleared by a stat_rd in a cycle whose reported code is 0x02, and by no other read. A new thr_evt in the clearing cycle wins.
- R9: The line flag clears on line_rd and the modem flag clears on modem_rd. A set pulse in the same cycle wins.
- R10: Receive data and receive timeout follow the rx_avail and rx_tmo levels in the same cycle, with no stored state.
- R11: The CTS/RTS flag is set by flow_chg while ext_en is 1. It is cleared by a stat_rd in a cycle whose reported code is 0x20.
- R12: Clearing a src_en bit hides that source without discarding its pending flag. Setting the bit again reveals the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_on | input | 1 | FIFO mode flag |
| ext_en | input | 1 | Extended-feature enable |
| src_en | input | 7 | Per-source enable mask |
| line_err | input | 1 | Line error pulse |
| line_rd | input | 1 | Line status register read strobe |
| rx_avail | input | 1 | Receive data ready level |
| rx_tmo | input | 1 | Receive timeout level |
| thr_evt | input | 1 | Transmit holding empty pulse |
| modem_chg | input | 1 | Modem status change pulse |
| modem_rd | input | 1 | Modem status register read strobe |
| xoff_hit | input | 1 | Xoff or special character match pulse |
| xon_hit | input | 1 | Xon character match pulse |
| flow_chg | input | 1 | CTS/RTS change pulse |
| stat_rd | input | 1 | Status register read strobe |
| stat | output | 8 | Status code |
| irq | output | 1 | Active-high interrupt |

## Verification
The bench first applies one source at a time to confirm each code. It then applies stacked sources, which separate a correct priority order from a swapped one, especially between the two receive sources. Reads are issued while a lower or a higher source is on top. This shows whether the transmit and CTS/RTS flags clear only when they are the reported source. Xoff/Xon and ext_en toggling patterns separate sticky from read-cleared behaviour and gating from discarding. A long randomized phase then compares every cycle against a behavioural model.

// File: rtl/uis_pkg.sv
package uis_pkg;

    localparam int NSRC   = 7;
    localparam int CODE_W = 6;
    localparam int STAT_W = CODE_W + 2;

    // enable-mask bit positions
    localparam int EN_LINE = 0;
    localparam int EN_RXD  = 1;
    localparam int EN_TMO  = 2;
    localparam int EN_THR  = 3;
    localparam int EN_MDM  = 4;
    localparam int EN_XOFF = 5;
    localparam int EN_FLOW = 6;

    localparam logic [CODE_W-1:0] C_LINE = 6'h06;
    localparam logic [CODE_W-1:0] C_TMO  = 6'h0C;
    localparam logic [CODE_W-1:0] C_RXD  = 6'h04;
    localparam logic [CODE_W-1:0] C_THR  = 6'h02;
    localparam logic [CODE_W-1:0] C_MDM  = 6'h00;
    localparam logic [CODE_W-1:0] C_XOFF = 6'h10;
    localparam logic [CODE_W-1:0] C_FLOW = 6'h20;
    localparam logic [CODE_W-1:0] C_IDLE = 6'h01;

    typedef struct packed {
        logic line;
        logic thr;
        logic mdm;
        logic xoff;
        logic flow;
    } flags_t;

    // rank 0 is most urgent
    function automatic logic [CODE_W-1:0] rank_code(input int r);
        case (r)
            0:       return C_LINE;
            1:       return C_TMO;
            2:       return C_RXD;
            3:       return C_THR;
            4:       return C_MDM;
            5:       return C_XOFF;
            default: return C_FLOW;
        endcase
    endfunction

    function automatic int rank_en(input int r);
        case (r)
            0:       return EN_LINE;
            1:       return EN_TMO;
            2:       return EN_RXD;
            3:       return EN_THR;
            4:       return EN_MDM;
            5:       return EN_XOFF;
            default: return EN_FLOW;
        endcase
    endfunction

endpackage

// File: rtl/uis_flags.sv
module uis_flags
    import uis_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_en,
    input  logic              line_err,
    input  logic              line_rd,
    input  logic              thr_evt,
    input  logic              modem_chg,
    input  logic              modem_rd,
    input  logic              xoff_hit,
    input  logic              xon_hit,
    input  logic              flow_chg,
    input  logic              stat_rd,
    input  logic [CODE_W-1:0] shown_code,
    input  logic              shown_idle,
    output flags_t            flg
);

    flags_t flg_d, flg_q;
    logic   thr_taken, flow_taken;

    always_comb begin
        thr_taken  = stat_rd && !shown_idle && (shown_code == C_THR);
        flow_taken = stat_rd && !shown_idle && (shown_code == C_FLOW);

        flg_d = flg_q;

        if (line_rd)      flg_d.line = 1'b0;
        if (line_err)     flg_d.line = 1'b1;

        if (thr_taken)    flg_d.thr  = 1'b0;
        if (thr_evt)      flg_d.thr  = 1'b1;

        if (modem_rd)     flg_d.mdm  = 1'b0;
        if (modem_chg)    flg_d.mdm  = 1'b1;

        if (xon_hit)              flg_d.xoff = 1'b0;
        if (xoff_hit && ext_en)   flg_d.xoff = 1'b1;

        if (flow_taken)           flg_d.flow = 1'b0;
        if (flow_chg && ext_en)   flg_d.flow = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= flg_d;
    end

    assign flg = flg_q;

endmodule

// File: rtl/uis_prio.sv
module uis_prio
    import uis_pkg::*;
(
    input  flags_t            flg,
    input  logic              rx_avail,
    input  logic              rx_tmo,
    input  logic [NSRC-1:0]   src_en,
    input  logic              ext_en,
    output logic [CODE_W-1:0] code,
    output logic              idle
);

    logic [NSRC-1:0] raw;   // indexed by rank
    logic [NSRC-1:0] req;

    always_comb begin
        raw    = '0;
        raw[0] = flg.line;
        raw[1] = rx_tmo;
        raw[2] = rx_avail;
        raw[3] = flg.thr;
        raw[4] = flg.mdm;
        raw[5] = flg.xoff && ext_en;
        raw[6] = flg.flow && ext_en;
    end

    for (genvar r = 0; r < NSRC; r++) begin : g_mask
        assign req[r] = raw[r] && src_en[rank_en(r)];
    end

    always_comb begin
        code = C_IDLE;
        idle = 1'b1;
        for (int r = NSRC - 1; r >= 0; r--) begin
            if (req[r]) begin
                code = rank_code(r);
                idle = 1'b0;
            end
        end
    end

endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
    import uis_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_on,
    input  logic              ext_en,
    input  logic [NSRC-1:0]   src_en,
    input  logic              line_err,
    input  logic              line_rd,
    input  logic              rx_avail,
    input  logic              rx_tmo,
    input  logic              thr_evt,
    input  logic              modem_chg,
    input  logic              modem_rd,
    input  logic              xoff_hit,
    input  logic              xon_hit,
    input  logic              flow_chg,
    input  logic              stat_rd,
    output logic [STAT_W-1:0] stat,
    output logic              irq
);

    flags_t            flg;
    logic [CODE_W-1:0] code;
    logic              idle;

    uis_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_en     (ext_en),
        .line_err   (line_err),
        .line_rd    (line_rd),
        .thr_evt    (thr_evt),
        .modem_chg  (modem_chg),
        .modem_rd   (modem_rd),
        .xoff_hit   (xoff_hit),
        .xon_hit    (xon_hit),
        .flow_chg   (flow_chg),
        .stat_rd    (stat_rd),
        .shown_code (code),
        .shown_idle (idle),
        .flg        (flg)
    );

    uis_prio u_prio (
        .flg      (flg),
        .rx_avail (rx_avail),
        .rx_tmo   (rx_tmo),
        .src_en   (src_en),
        .ext_en   (ext_en),
        .code     (code),
        .idle     (idle)
    );

    assign stat = {{(STAT_W-CODE_W){fifo_on}}, code};
    assign irq  = !idle;

endmodule

// File: rtl/uis_chk.sv
module uis_chk
    import uis_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ext_en,
    input logic [NSRC-1:0]   src_en,
    input logic              line_err,
    input logic              thr_evt,
    input logic              modem_chg,
    input logic              modem_rd,
    input logic              xon_hit,
    input logic              stat_rd,
    input logic [STAT_W-1:0] stat,
    input logic              irq
);

    // R3: a line error outranks everything on the next cycle
    a_r3_line_first: assert property (@(posedge clk) disable iff (!rst_n)
        line_err ##1 src_en[EN_LINE] |-> stat[5:0] == C_LINE);

    // R5: extended bits stay low with the extension off
    a_r5_ext_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_en |-> stat[5:4] == 2'b00);

    // R6: the Xoff flag survives anything but Xon
    a_r6_xoff_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[5:0] == C_XOFF && !xon_hit) ##1 (ext_en && src_en[EN_XOFF])
        |-> (!stat[0] && stat[5:0] != C_FLOW));

    // R7: idle code carries no source bits, and irq tracks a pending source
    a_r7_idle_clean: assert property (@(posedge clk) disable iff (!rst_n)
        stat[0] |-> (stat[5:1] == 5'b0 && !irq));

    // R8: a read of the transmit code retires it
    a_r8_thr_retire: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && stat[5:0] == C_THR && !thr_evt) |=> stat[5:0] != C_THR);

    // R9: a modem read retires the modem source
    a_r9_modem_retire: assert property (@(posedge clk) disable iff (!rst_n)
        (modem_rd && !modem_chg) |=> stat[5:0] != C_MDM);

endmodule

bind uart_irq_status uis_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_en    (ext_en),
    .src_en    (src_en),
    .line_err  (line_err),
    .thr_evt   (thr_evt),
    .modem_chg (modem_chg),
    .modem_rd  (modem_rd),
    .xon_hit   (xon_hit),
    .stat_rd   (stat_rd),
    .stat      (stat),
    .irq       (irq)
);

// File: tb/sim_uart_irq_status.sv
`timescale 1ns/1ps
module sim_uart_irq_status;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       fifo_on = 0, ext_en = 0;
    logic [6:0] src_en = '1;
    logic       line_err = 0, line_rd = 0, rx_avail = 0, rx_tmo = 0;
    logic       thr_evt = 0, modem_chg = 0, modem_rd = 0;
    logic       xoff_hit = 0, xon_hit = 0, flow_chg = 0, stat_rd = 0;
    logic [7:0] stat;
    logic       irq;

    int n_run = 0, n_fail = 0;
    bit model_on = 0;

    // behavioural model state
    int m_line = 0, m_thr = 0, m_mdm = 0, m_xoff = 0, m_flow = 0;

    always #10 clk = ~clk;

    uart_irq_status u0 (
        .clk(clk), .rst_n(rst_n), .fifo_on(fifo_on), .ext_en(ext_en),
        .src_en(src_en), .line_err(line_err), .line_rd(line_rd),
        .rx_avail(rx_avail), .rx_tmo(rx_tmo), .thr_evt(thr_evt),
        .modem_chg(modem_chg), .modem_rd(modem_rd), .xoff_hit(xoff_hit),
        .xon_hit(xon_hit), .flow_chg(flow_chg), .stat_rd(stat_rd),
        .stat(stat), .irq(irq)
    );

    function automatic int exp_low();
        if (m_line && src_en[0])           return 'h06;
        if (rx_tmo && src_en[2])           return 'h0C;
        if (rx_avail && src_en[1])         return 'h04;
        if (m_thr && src_en[3])            return 'h02;
        if (m_mdm && src_en[4])            return 'h00;
        if (ext_en && m_xoff && src_en[5]) return 'h10;
        if (ext_en && m_flow && src_en[6]) return 'h20;
        return 'h01;
    endfunction

    function automatic int exp_stat();
        return (fifo_on ? 'hC0 : 0) + exp_low();
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_line <= 0; m_thr <= 0; m_mdm <= 0; m_xoff <= 0; m_flow <= 0;
        end else begin
            int shown;
            shown = exp_low();
            m_line <= line_err ? 1 : (line_rd ? 0 : m_line);
            m_thr  <= thr_evt ? 1 : ((stat_rd && shown == 'h02) ? 0 : m_thr);
            m_mdm  <= modem_chg ? 1 : (modem_rd ? 0 : m_mdm);
            m_xoff <= (xoff_hit && ext_en) ? 1 : (xon_hit ? 0 : m_xoff);
            m_flow <= (flow_chg && ext_en) ? 1 : ((stat_rd && shown == 'h20) ? 0 : m_flow);
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    // per-cycle comparison against the model (R2 codes, R7 irq)
    always @(negedge clk) begin
        if (model_on && rst_n) begin
            chk("R2 model", stat, exp_stat());
            chk("R7 irq", irq, (exp_low() == 'h01) ? 0 : 1);
        end
    end

    task automatic clr_pulses();
        line_err = 0; line_rd = 0; thr_evt = 0; modem_chg = 0; modem_rd = 0;
        xoff_hit = 0; xon_hit = 0; flow_chg = 0; stat_rd = 0;
    endtask

    // apply current inputs for one edge, then drop pulses at the falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        #1 clr_pulses();
    endtask

    initial begin : watchdog
        #3_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset stat", stat, 'h01);
        chk("R1 reset irq", irq, 0);
        rst_n = 1;
        @(negedge clk);
        model_on = 1;
        chk("R1 after release", stat, 'h01);

        // R4: FIFO mode bits
        fifo_on = 1; #1;
        chk("R4 fifo bits", stat, 'hC1);
        fifo_on = 0;

        // R2/R3: stacked sources resolved in order
        ext_en = 1;
        flow_chg = 1; xoff_hit = 1; modem_chg = 1; thr_evt = 1; line_err = 1;
        step();
        rx_avail = 1; rx_tmo = 1; #1;
        chk("R3 line first", stat, 'h06);
        line_rd = 1; step();
        chk("R3 timeout next", stat, 'h0C);
        rx_tmo = 0; #1;
        chk("R10 rx data level", stat, 'h04);
        // R8: read while rx data shown leaves transmit flag intact
        stat_rd = 1; step();
        rx_avail = 0; #1;
        chk("R8 thr survives other read", stat, 'h02);
        stat_rd = 1; step();
        chk("R9 modem next", stat, 'h00);
        chk("R7 irq on modem code", irq, 1);
        modem_rd = 1; step();
        chk("R6 xoff shown", stat, 'h10);
        stat_rd = 1; step();
        chk("R6 xoff survives read", stat, 'h10);
        // R12: mask hides without losing
        src_en[5] = 0; #1;
        chk("R12 masked", stat, 'h20);
        src_en[5] = 1; #1;
        chk("R12 unmasked", stat, 'h10);
        // R5: extension off hides both
        ext_en = 0; #1;
        chk("R5 ext off idle", stat, 'h01);
        xoff_hit = 1; flow_chg = 1; step();
        ext_en = 1; #1;
        chk("R5 flags kept", stat, 'h10);
        xon_hit = 1; step();
        chk("R11 flow shown", stat, 'h20);
        stat_rd = 1; step();
        chk("R11 flow retired", stat, 'h01);
        // R6: both xoff and xon same cycle -> set
        xoff_hit = 1; xon_hit = 1; step();
        chk("R6 set wins", stat, 'h10);
        xon_hit = 1; step();
        // R8/R9: set wins over clear
        thr_evt = 1; step();
        stat_rd = 1; thr_evt = 1; step();
        chk("R8 set wins", stat, 'h02);
        stat_rd = 1; step();
        line_err = 1; line_rd = 1; step();
        chk("R9 set wins", stat, 'h06);
        line_rd = 1; step();
        chk("R9 line retired", stat, 'h01);

        // randomized phase, model compared every cycle
        for (int i = 0; i < 4000; i++) begin
            fifo_on   = ($urandom % 16) == 0 ? ~fifo_on : fifo_on;
            ext_en    = ($urandom % 20) == 0 ? ~ext_en : ext_en;
            if (($urandom % 25) == 0) src_en = 7'($urandom);
            line_err  = ($urandom % 12) == 0;
            line_rd   = ($urandom % 6) == 0;
            rx_avail  = ($urandom % 5) == 0;
            rx_tmo    = ($urandom % 9) == 0;
            thr_evt   = ($urandom % 8) == 0;
            modem_chg = ($urandom % 10) == 0;
            modem_rd  = ($urandom % 6) == 0;
            xoff_hit  = ($urandom % 15) == 0;
            xon_hit   = ($urandom % 10) == 0;
            flow_chg  = ($urandom % 12) == 0;
            stat_rd   = ($urandom % 3) == 0;
            step();
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule